// File: doc/BRIEF.md
# DMA Channel Size Sequencer with Auto-Alignment

This block sequences the address phase of one DMA channel block move. It is given a source and destination address, a programmed access size for each side, an increment enable for each side, a byte count and an auto-align enable. From these it produces a stream of read beats and a stream of write beats. Each beat carries an address and a size code. The block steps both addresses, counts down the bytes that remain, and checks the setup for configuration errors when the move starts.

One side is the lead side. It is the source when the source size is at least as wide as the destination size, and the destination otherwise. Each access is one beat on the lead side and one or more narrower beats on the other side, which is the follower. With auto-alignment off, every access has the lead's programmed size. With auto-alignment on, the access size changes during the move. The lead address first climbs to its programmed size boundary using narrower accesses. The last bytes are then sized by the count that remains. Only the follower's setup is checked for errors in this mode.

Read and write beats leave through valid/ready interfaces. A beat is taken in a cycle where both valid and ready are high. While ready is low, valid, address and size hold steady. Only one of the two streams is offered at any time, so at most one beat moves per cycle. `start`, `busy`, `done` and `cfg_err` are plain level pins.

Top module: `dma_align_seq`

## Requirements
- R1: Size codes are 00 for 4 bytes, 01 for 1 byte and 10 for 2 bytes. A code of 11 on either side makes the start a configuration error: `cfg_err` is set, no beat is issued, and `done` pulses in the cycle after the start.
- R2: With `align_en` low, every lead beat uses the lead's programmed size. The setup is an error when either address is not a multiple of its own side's size, or when the byte count is not a multiple of the lead size.
- R3: The source is the lead when its size in bytes is greater than or equal to the destination's; otherwise the destination leads. When the source leads, each access is one read followed by the writes. When the destination leads, each access is the reads followed by one write.
- R4: With `align_en` high, each access takes the largest of 4, 2 and 1 bytes that meets three limits: it is no larger than the lead's programmed size, it is no larger than the bytes left, and the lead address is a multiple of it.
- R5: With `align_en` high, the lead address steps by the access size after each access, whatever its increment enable is. With `align_en` low, the lead address steps only when its increment enable is set.
- R6: Follower beats use the smaller of the follower's programmed size and the access size. There are as many beats as it takes to cover the access. The follower address steps by the beat size after each beat when its increment enable is set; otherwise it stays fixed.
- R7: With `align_en` high, a misaligned lead address is not an error. A follower address that is not a multiple of the follower size is an error.
- R8: After the handshake of the last write, `done` is high for exactly one cycle and `busy` is low from that cycle on. A start with a byte count of zero and no error gives a `done` pulse in the next cycle and issues no beats. `cfg_err` reflects the most recent start and holds until the next start.
- R9: A pending beat keeps valid, address and size stable until it is accepted. Read valid and write valid are never high together, and neither is high while `busy` is low.
- R10: A start seen while `busy` is high is ignored. The move in progress continues with its original setup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a move when the channel is idle |
| align_en | input | 1 | Auto-alignment enable |
| src_size | input | 2 | Source size code |
| dst_size | input | 2 | Destination size code |
| src_inc | input | 1 | Source address increment enable |
| dst_inc | input | 1 | Destination address increment enable |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| byte_count | input | CW | Bytes to move |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle end-of-move pulse |
| cfg_err | output | 1 | Last start had a configuration error |
| rd_valid | output | 1 | Read beat offered |
| rd_ready | input | 1 | Read beat accepted |
| rd_addr | output | AW | Read beat address |
| rd_size | output | 2 | Read beat size code |
| wr_valid | output | 1 | Write beat offered |
| wr_ready | input | 1 | Write beat accepted |
| wr_addr | output | AW | Write beat address |
| wr_size | output | 2 | Write beat size code |

## Verification
The assertions assume that reset is applied before the first start. They also assume that the ready inputs may change freely, because they never need ready to stay high once a beat is pending. They rely on no start-time inputs other than the size codes, which show up on the beat size outputs. The stimulus drives every input only between clock edges. It lets ready drop at random to exercise the hold rule. Most random size codes are legal, with the reserved code mixed in. Addresses and counts are kept small, so a move ends within a few hundred beats and nothing wraps.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } xsize_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } seq_st_e;

  // Byte width of a size code; the reserved code maps to zero.
  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      SZ_LONG: return 3'd4;
      SZ_BYTE: return 3'd1;
      SZ_WORD: return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [2:0] nbytes);
    case (nbytes)
      3'd4:    return SZ_LONG;
      3'd2:    return SZ_WORD;
      default: return SZ_BYTE;
    endcase
  endfunction

  // True when the low address bits break natural alignment for the code.
  function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] code);
    case (code)
      SZ_LONG: return lo != 2'b00;
      SZ_WORD: return lo[0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/dma_size_pick.sv
module dma_size_pick
  import dma_seq_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          align_en,
  input  logic [1:0]    prog,
  input  logic [1:0]    addr_lo,
  input  logic [CW-1:0] remain,
  output logic [2:0]    acc_bytes
);

  localparam logic [CW-1:0] FOUR = CW'(4);
  localparam logic [CW-1:0] TWO  = CW'(2);

  always_comb begin
    if (!align_en) begin
      acc_bytes = size_bytes(prog);
    end else if (prog == SZ_LONG && addr_lo == 2'b00 && remain >= FOUR) begin
      acc_bytes = 3'd4;
    end else if ((prog == SZ_LONG || prog == SZ_WORD) && !addr_lo[0] && remain >= TWO) begin
      acc_bytes = 3'd2;
    end else begin
      acc_bytes = 3'd1;
    end
  end

endmodule

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
  import dma_seq_pkg::*;
(
  input  logic       align_en,
  input  logic [1:0] src_code,
  input  logic [1:0] dst_code,
  input  logic [1:0] src_lo,
  input  logic [1:0] dst_lo,
  input  logic [1:0] count_lo,
  output logic       lead_src,
  output logic       err
);

  logic [1:0] lead_code, follow_code, lead_lo, follow_lo;
  logic       rsvd, count_ragged, lead_bad, follow_bad;

  always_comb begin
    lead_src    = size_bytes(src_code) >= size_bytes(dst_code);
    lead_code   = lead_src ? src_code : dst_code;
    follow_code = lead_src ? dst_code : src_code;
    lead_lo     = lead_src ? src_lo : dst_lo;
    follow_lo   = lead_src ? dst_lo : src_lo;
    rsvd        = (src_code == SZ_RSVD) || (dst_code == SZ_RSVD);
    case (lead_code)
      SZ_LONG: count_ragged = count_lo != 2'b00;
      SZ_WORD: count_ragged = count_lo[0];
      default: count_ragged = 1'b0;
    endcase
    lead_bad   = misaligned(lead_lo, lead_code) || count_ragged;
    follow_bad = misaligned(follow_lo, follow_code);
    err        = rsvd || follow_bad || (!align_en && lead_bad);
  end

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  input  logic          step_en,
  input  logic [2:0]    step,
  output logic [AW-1:0] addr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_addr;
    end else if (step_en) begin
      addr <= addr + AW'(step);
    end
  end

endmodule

// File: rtl/dma_align_seq.sv
module dma_align_seq
  import dma_seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          align_en,
  input  logic [1:0]    src_size,
  input  logic [1:0]    dst_size,
  input  logic          src_inc,
  input  logic          dst_inc,
  input  logic [AW-1:0] src_addr,
  input  logic [AW-1:0] dst_addr,
  input  logic [CW-1:0] byte_count,
  output logic          busy,
  output logic          done,
  output logic          cfg_err,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  output logic [1:0]    rd_size,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [1:0]    wr_size
);

  localparam int NSIDE = 2;   // index 0 = source (read), 1 = destination (write)
  localparam int BW    = 3;   // beat counter, up to 4 beats per access

  seq_st_e              state;
  logic                 lead_src_q, align_q;
  logic [NSIDE-1:0][1:0] code_q;
  logic [NSIDE-1:0]     inc_q;
  logic [CW-1:0]        remain_q;
  logic [BW-1:0]        beat_q;
  logic                 done_q, err_q;

  logic [AW-1:0]        addr_w  [NSIDE];
  logic [AW-1:0]        init_w  [NSIDE];
  logic [NSIDE-1:0]     step_en_w;
  logic [2:0]           step_w  [NSIDE];
  logic [NSIDE-1:0]     fire_w;

  logic                 chk_lead_src, chk_err, accept;
  logic [1:0]           lead_code, follow_code, lead_lo;
  logic [2:0]           acc, follow_bytes, fb;
  logic [BW-1:0]        nbeats, rd_beats, wr_beats;
  logic [2:0]           rd_bytes, wr_bytes;
  logic                 last_rd, last_wr, access_end;

  // Start-time configuration check on the raw inputs.
  dma_cfg_check u_check (
    .align_en (align_en),
    .src_code (src_size),
    .dst_code (dst_size),
    .src_lo   (src_addr[1:0]),
    .dst_lo   (dst_addr[1:0]),
    .count_lo (byte_count[1:0]),
    .lead_src (chk_lead_src),
    .err      (chk_err)
  );

  assign accept = start && (state == ST_IDLE);

  always_comb begin
    lead_code   = lead_src_q ? code_q[0] : code_q[1];
    follow_code = lead_src_q ? code_q[1] : code_q[0];
    lead_lo     = lead_src_q ? addr_w[0][1:0] : addr_w[1][1:0];
  end

  // Access size from the lead address and the bytes left.
  dma_size_pick #(.CW(CW)) u_pick (
    .align_en  (align_q),
    .prog      (lead_code),
    .addr_lo   (lead_lo),
    .remain    (remain_q),
    .acc_bytes (acc)
  );

  always_comb begin
    follow_bytes = size_bytes(follow_code);
    fb           = (follow_bytes < acc) ? follow_bytes : acc;
    case (fb)
      3'd4:    nbeats = BW'(acc >> 2);
      3'd2:    nbeats = BW'(acc >> 1);
      default: nbeats = BW'(acc);
    endcase
    rd_bytes   = lead_src_q ? acc : fb;
    wr_bytes   = lead_src_q ? fb : acc;
    rd_beats   = lead_src_q ? BW'(1) : nbeats;
    wr_beats   = lead_src_q ? nbeats : BW'(1);
    fire_w[0]  = rd_valid && rd_ready;
    fire_w[1]  = wr_valid && wr_ready;
    last_rd    = (beat_q + BW'(1)) == rd_beats;
    last_wr    = (beat_q + BW'(1)) == wr_beats;
    access_end = fire_w[1] && last_wr;
  end

  assign init_w[0] = src_addr;
  assign init_w[1] = dst_addr;

  // One address counter per side; the lead steps once per access, the
  // follower once per beat.
  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    logic is_lead;
    assign is_lead = (s == 0) ? lead_src_q : !lead_src_q;
    assign step_en_w[s] = is_lead ? (access_end && (align_q || inc_q[s]))
                                  : (fire_w[s] && inc_q[s]);
    assign step_w[s]    = is_lead ? acc : fb;

    dma_addr_ctr #(.AW(AW)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .load_addr (init_w[s]),
      .step_en   (step_en_w[s]),
      .step      (step_w[s]),
      .addr      (addr_w[s])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      lead_src_q <= 1'b1;
      align_q    <= 1'b0;
      code_q     <= '0;
      inc_q      <= '0;
      remain_q   <= '0;
      beat_q     <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            lead_src_q <= chk_lead_src;
            align_q    <= align_en;
            code_q     <= {dst_size, src_size};
            inc_q      <= {dst_inc, src_inc};
            remain_q   <= byte_count;
            beat_q     <= '0;
            err_q      <= chk_err;
            if (chk_err || byte_count == '0) begin
              done_q <= 1'b1;
            end else begin
              state <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (fire_w[0]) begin
            if (last_rd) begin
              state  <= ST_WR;
              beat_q <= '0;
            end else begin
              beat_q <= beat_q + BW'(1);
            end
          end
        end
        ST_WR: begin
          if (fire_w[1]) begin
            if (last_wr) begin
              beat_q   <= '0;
              remain_q <= remain_q - CW'(acc);
              if (remain_q == CW'(acc)) begin
                state  <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                state <= ST_RD;
              end
            end else begin
              beat_q <= beat_q + BW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = done_q;
  assign cfg_err  = err_q;
  assign rd_valid = (state == ST_RD);
  assign wr_valid = (state == ST_WR);
  assign rd_addr  = addr_w[0];
  assign wr_addr  = addr_w[1];
  assign rd_size  = size_code(rd_bytes);
  assign wr_size  = size_code(wr_bytes);

endmodule

// File: rtl/dma_align_seq_chk.sv
module dma_align_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          cfg_err,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic [1:0]    rd_size,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic [1:0]    wr_size
);

  AST_ONE_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R9

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_size)); // R9

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_size)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_valid && !wr_valid); // R9

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_NO_RSVD_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_size != 2'b11); // R1

  AST_NO_RSVD_WR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_size != 2'b11); // R1

  AST_ERR_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy); // R2

endmodule

bind dma_align_seq dma_align_seq_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .cfg_err  (cfg_err),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_addr  (rd_addr),
  .rd_size  (rd_size),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_addr  (wr_addr),
  .wr_size  (wr_size)
);

// File: tb/test_dma_align_seq.sv
module test_dma_align_seq;

  localparam int AW = 32;
  localparam int CW = 16;
  localparam int MAXB = 512;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          align_en = 1'b0;
  logic [1:0]    src_size = 2'b00;
  logic [1:0]    dst_size = 2'b00;
  logic          src_inc = 1'b0;
  logic          dst_inc = 1'b0;
  logic [AW-1:0] src_addr = '0;
  logic [AW-1:0] dst_addr = '0;
  logic [CW-1:0] byte_count = '0;
  logic          busy, done, cfg_err;
  logic          rd_valid, wr_valid;
  logic          rd_ready = 1'b0;
  logic          wr_ready = 1'b0;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [1:0]    rd_size, wr_size;

  int total = 0;
  int bad = 0;

  int        exp_n;
  bit        exp_err;
  bit        exp_dir [MAXB];
  bit [31:0] exp_a   [MAXB];
  bit [1:0]  exp_s   [MAXB];

  always #10 clk = ~clk;

  dma_align_seq #(.AW(AW), .CW(CW)) i_dma_align_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .align_en(align_en),
    .src_size(src_size), .dst_size(dst_size), .src_inc(src_inc), .dst_inc(dst_inc),
    .src_addr(src_addr), .dst_addr(dst_addr), .byte_count(byte_count),
    .busy(busy), .done(done), .cfg_err(cfg_err),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_size(rd_size),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_size(wr_size)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Size code table from R1.
  function automatic int nb(input bit [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 1;
      2'b10: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic bit badal(input bit [31:0] a, input bit [1:0] c);
    int w = nb(c);
    if (w == 0) return 1'b0;
    return (a % w) != 0;
  endfunction

  task automatic push(input bit dir, input bit [31:0] a, input int n);
    if (exp_n < MAXB) begin
      exp_dir[exp_n] = dir;
      exp_a[exp_n]   = a;
      exp_s[exp_n]   = (n == 4) ? 2'b00 : (n == 2) ? 2'b10 : 2'b01;
    end
    exp_n++;
  endtask

  // Expected beat list built from R1..R7.
  task automatic build(input bit al, input bit [1:0] ss, input bit [1:0] ds,
                       input bit [31:0] sa, input bit [31:0] da,
                       input bit si, input bit di, input int cnt);
    bit ls;
    bit [1:0] lc, fc;
    bit [31:0] la, fa;
    bit li, fi;
    int rem, acc, fb, k;
    exp_n = 0;
    ls = nb(ss) >= nb(ds);
    lc = ls ? ss : ds;  fc = ls ? ds : ss;
    la = ls ? sa : da;  fa = ls ? da : sa;
    li = ls ? si : di;  fi = ls ? di : si;
    exp_err = (ss == 2'b11) || (ds == 2'b11) || badal(fa, fc) ||
              (!al && (badal(la, lc) || (nb(lc) != 0 && (cnt % nb(lc)) != 0)));
    if (exp_err) return;
    rem = cnt;
    while (rem > 0) begin
      if (!al) acc = nb(lc);
      else if (nb(lc) == 4 && la % 4 == 0 && rem >= 4) acc = 4;
      else if (nb(lc) >= 2 && la % 2 == 0 && rem >= 2) acc = 2;
      else acc = 1;
      fb = (nb(fc) < acc) ? nb(fc) : acc;
      k = acc / fb;
      if (ls) push(1'b0, la, acc);
      for (int j = 0; j < k; j++) begin
        push(ls ? 1'b1 : 1'b0, fa, fb);
        if (fi) fa = fa + fb;
      end
      if (!ls) push(1'b1, la, acc);
      if (al || li) la = la + acc;
      rem = rem - acc;
    end
  endtask

  task automatic run_case(input string tag, input bit al, input bit [1:0] ss,
                          input bit [1:0] ds, input bit [31:0] sa, input bit [31:0] da,
                          input bit si, input bit di, input int cnt,
                          input int rdy_pct, input bit hold);
    int idx = 0;
    int cyc = 0;
    bit got = 0;
    bit is_rd, is_wr;
    build(al, ss, ds, sa, da, si, di, cnt);
    @(negedge clk);
    align_en = al; src_size = ss; dst_size = ds; src_addr = sa; dst_addr = da;
    src_inc = si; dst_inc = di; byte_count = CW'(cnt); start = 1'b1;
    @(negedge clk);
    if (hold) begin
      // R10: a changed setup offered while busy must be ignored
      align_en = ~al; src_size = 2'b01; dst_size = 2'b01;
      src_addr = 32'h0000_0f00; dst_addr = 32'h0000_0e00; byte_count = CW'(3);
    end else begin
      start = 1'b0;
    end
    check(busy == (exp_n != 0), {tag, " R8 busy after start"}, "busy", busy, exp_n != 0);
    while (!got && cyc < 4000) begin
      if (cyc >= 3) start = 1'b0;
      rd_ready = ($urandom % 100) < rdy_pct;
      wr_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (done) begin
        got = 1;
      end else begin
        is_rd = rd_valid && rd_ready;
        is_wr = wr_valid && wr_ready;
        if (is_rd || is_wr) begin
          if (idx >= exp_n) begin
            check(1'b0, {tag, " R8 extra beat"}, "beat index", idx, exp_n);
          end else begin
            check(is_wr == exp_dir[idx], {tag, " R3 beat direction"}, "dir", is_wr, exp_dir[idx]);
            check((is_wr ? wr_addr : rd_addr) == exp_a[idx], {tag, " beat address"},
                  "addr", is_wr ? wr_addr : rd_addr, exp_a[idx]);
            check((is_wr ? wr_size : rd_size) == exp_s[idx], {tag, " beat size"},
                  "size", is_wr ? wr_size : rd_size, exp_s[idx]);
          end
          idx++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    check(got, {tag, " R8 done seen"}, "done", got, 1);
    check(!busy, {tag, " R8 busy low at done"}, "busy", busy, 0);
    check(idx == exp_n, {tag, " R8 beat count"}, "beats", idx, exp_n);
    check(cfg_err == exp_err, {tag, " R1 R7 cfg_err"}, "cfg_err", cfg_err, exp_err);
    @(negedge clk);
    #1;
    check(!done, {tag, " R8 done one cycle"}, "done", done, 0);
    rd_ready = 1'b0;
    wr_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    check(!busy && !done && !cfg_err && !rd_valid && !wr_valid, "R8 reset state",
          "outputs", {busy, done, cfg_err, rd_valid, wr_valid}, 0);
    rst_n = 1'b1;

    // R4 R5: long source from 0x1 to a byte sink, 0xF0 bytes, source inc off
    run_case("R4 R5 R6 example", 1'b1, 2'b00, 2'b01, 32'h1, 32'h100, 1'b0, 1'b1, 'hF0, 70, 1'b0);
    // R4 tail: remaining bytes pick the size
    run_case("R4 tail", 1'b1, 2'b00, 2'b01, 32'h4, 32'h200, 1'b1, 1'b1, 7, 100, 1'b0);
    // R3 R5: destination leads, its increment off, still advances under alignment
    run_case("R3 R5 dst lead", 1'b1, 2'b01, 2'b00, 32'h40, 32'h13, 1'b1, 1'b0, 20, 60, 1'b0);
    // R2 R3 R6: no alignment, byte source into long sink, four reads per write
    run_case("R2 R3 R6 fixed", 1'b0, 2'b01, 2'b00, 32'h80, 32'h300, 1'b1, 1'b1, 16, 80, 1'b0);
    // R6: follower fixed address when its increment is off
    run_case("R6 follower fixed", 1'b0, 2'b00, 2'b10, 32'h20, 32'h50, 1'b1, 1'b0, 12, 90, 1'b0);
    // R1: reserved code
    run_case("R1 reserved", 1'b1, 2'b11, 2'b01, 32'h0, 32'h0, 1'b1, 1'b1, 8, 100, 1'b0);
    // R7: lead misaligned is fine, follower misaligned is an error
    run_case("R7 lead skew ok", 1'b1, 2'b00, 2'b10, 32'h3, 32'h10, 1'b1, 1'b1, 10, 100, 1'b0);
    run_case("R7 follower skew", 1'b1, 2'b00, 2'b10, 32'h3, 32'h11, 1'b1, 1'b1, 10, 100, 1'b0);
    // R2: misaligned lead and ragged count without alignment
    run_case("R2 lead skew", 1'b0, 2'b00, 2'b01, 32'h2, 32'h0, 1'b1, 1'b1, 8, 100, 1'b0);
    run_case("R2 ragged count", 1'b0, 2'b00, 2'b01, 32'h0, 32'h0, 1'b1, 1'b1, 6, 100, 1'b0);
    // R8: zero count
    run_case("R8 zero count", 1'b1, 2'b00, 2'b00, 32'h0, 32'h0, 1'b1, 1'b1, 0, 100, 1'b0);
    // R10: start held high with a new setup while busy
    run_case("R10 start ignored", 1'b1, 2'b00, 2'b01, 32'h2, 32'h400, 1'b1, 1'b1, 24, 50, 1'b1);
    // R9: heavy back-pressure
    run_case("R9 backpressure", 1'b1, 2'b10, 2'b01, 32'h1, 32'h10, 1'b1, 1'b1, 9, 20, 1'b0);

    for (int t = 0; t < 60; t++) begin
      bit [1:0] ss = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      bit [1:0] ds = ($urandom % 8 == 0) ? 2'b11 : 2'($urandom % 3);
      bit [31:0] sa = ($urandom % 256);
      bit [31:0] da = ($urandom % 256);
      if ($urandom % 2 == 0) begin
        sa = sa & 32'hfc;
        da = da & 32'hfc;
      end
      run_case("R4 R6 random", 1'($urandom % 2), ss, ds, sa, da,
               1'($urandom % 2), 1'($urandom % 2), int'($urandom % 41),
               30 + int'($urandom % 71), 1'b0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule